// File: doc/BRIEF.md
# Branch Decision and Next-PC Unit

This unit resolves one jump instruction of a 64-bit packet-filter virtual machine per strobe. Given the current program counter (counted in 64-bit instruction slots), the jump class, the 4-bit condition code, the two operands and the displacement fields, it decides whether the jump is taken. It then produces the program counter of the next instruction to fetch, and flags encodings that do not name a valid jump.

Two jump classes share the condition codes. The wide class compares full 64-bit operands. The narrow class compares only the low halves, so the sign of a signed comparison is bit 31. The unconditional jump is the one place where the classes differ in displacement source. The wide class uses the 16-bit offset field, and the narrow class uses the 32-bit immediate, which gives long-range jumps. Every target is relative to the slot after the jump. With the default `REG_OUT = 1`, results appear one clock after the strobe and stay unchanged until the next strobe.

Top module: `bcu_branch_unit`

## Requirements
- R1: While `rst_n` is low, `o_vld`, `o_taken`, `o_illegal` and `o_next_pc` are all zero.
- R2: When a resolved instruction is not taken, including an illegal one, `o_next_pc` equals `i_pc + 1`, wrapping modulo 2^PC_W.
- R3: Code 0x0 with `i_use_reg = 0` is always taken. With `i_cls32 = 0` the target is `i_pc + 1 + sext(i_off)`. With `i_cls32 = 1` the target is `i_pc + 1 + sext(i_imm)`. Every conditional code uses `sext(i_off)` in both classes.
- R4: Code 0x1 is taken when the operands are equal. Code 0x5 is taken when they differ.
- R5: The unsigned orderings are taken on these relations of dst to the source operand: 0x2 greater, 0x3 greater-or-equal, 0xa less, 0xb less-or-equal.
- R6: The two's-complement orderings are taken on these relations: 0x6 greater, 0x7 greater-or-equal, 0xc less, 0xd less-or-equal.
- R7: Code 0x4 is taken when the bitwise AND of dst and the source operand is nonzero.
- R8: With `i_cls32 = 1`, every conditional compares only bits 31:0 of both operands, and bit 31 is the sign for the signed orderings. With `i_cls32 = 0`, all 64 bits are compared.
- R9: `i_use_reg = 1` selects `i_src` as the source operand. `i_use_reg = 0` selects `i_imm`, sign-extended to 64 bits before any narrowing.
- R10: Codes 0x8, 0x9, 0xe and 0xf, and code 0x0 with `i_use_reg = 1`, raise `o_illegal` and are never taken.
- R11: `o_vld` follows `i_vld` one clock later. After a cycle with `i_vld` low, `o_taken`, `o_illegal` and `o_next_pc` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_vld | input | 1 | Instruction strobe |
| i_pc | input | PC_W | Slot address of the jump |
| i_cls32 | input | 1 | 1 = narrow (32-bit) jump class, 0 = wide class |
| i_code | input | 4 | Condition code |
| i_use_reg | input | 1 | 1 = source register, 0 = immediate |
| i_dst | input | DATA_W | Destination operand |
| i_src | input | DATA_W | Source register operand |
| i_off | input | OFF_W | Signed slot offset |
| i_imm | input | IMM_W | Signed immediate |
| o_vld | output | 1 | Result strobe |
| o_taken | output | 1 | Jump taken |
| o_next_pc | output | PC_W | Next slot address |
| o_illegal | output | 1 | Encoding is not a valid jump |

## Verification
The next PC is the only state that leaves the unit, so a wrong comparison flag or a wrong displacement choice appears at the ports one clock after the strobe as a wrong `o_taken`/`o_next_pc` pair. A narrowing fault shows only when the upper halves disagree with the lower halves, and a sign-extension fault shows only when bit 31 of the immediate is set, so the stimulus places operands on those boundaries. A fault in the hold path shows in the first idle cycle after a result.

// File: rtl/bcu_pkg.sv
package bcu_pkg;

   typedef enum logic [3:0] {
      JC_ALWAYS = 4'h0,
      JC_EQ     = 4'h1,
      JC_UGT    = 4'h2,
      JC_UGE    = 4'h3,
      JC_TEST   = 4'h4,
      JC_NE     = 4'h5,
      JC_SGT    = 4'h6,
      JC_SGE    = 4'h7,
      JC_RSV8   = 4'h8,
      JC_RSV9   = 4'h9,
      JC_ULT    = 4'ha,
      JC_ULE    = 4'hb,
      JC_SLT    = 4'hc,
      JC_SLE    = 4'hd,
      JC_RSVE   = 4'he,
      JC_RSVF   = 4'hf
   } jcode_e;

   // relation flags of dst against the source operand
   typedef struct packed {
      logic eq;
      logic ult;
      logic slt;
      logic any;
   } cmp_flags_t;

endpackage

// File: rtl/bcu_operand_sel.sv
module bcu_operand_sel #(
   parameter int DATA_W = 64,
   parameter int IMM_W  = 32
) (
   input  logic [DATA_W-1:0] i_src,
   input  logic [IMM_W-1:0]  i_imm,
   input  logic              i_use_reg,
   output logic [DATA_W-1:0] o_b
);
   logic [DATA_W-1:0] imm_ext;

   assign imm_ext = DATA_W'($signed(i_imm));
   assign o_b     = i_use_reg ? i_src : imm_ext;
endmodule

// File: rtl/bcu_compare.sv
module bcu_compare
   import bcu_pkg::*;
#(
   parameter int W = 64
) (
   input  logic [W-1:0] i_a,
   input  logic [W-1:0] i_b,
   output cmp_flags_t   o_flags
);
   always_comb begin
      o_flags.eq  = (i_a == i_b);
      o_flags.ult = (i_a < i_b);
      o_flags.slt = ($signed(i_a) < $signed(i_b));
      o_flags.any = |(i_a & i_b);
   end
endmodule

// File: rtl/bcu_cond_decode.sv
module bcu_cond_decode
   import bcu_pkg::*;
(
   input  jcode_e     i_code,
   input  logic       i_use_reg,
   input  cmp_flags_t i_f,
   output logic       o_taken,
   output logic       o_illegal
);
   always_comb begin
      o_taken   = 1'b0;
      o_illegal = 1'b0;
      unique case (i_code)
         JC_ALWAYS: begin
            o_illegal = i_use_reg;
            o_taken   = ~i_use_reg;
         end
         JC_EQ:   o_taken = i_f.eq;
         JC_NE:   o_taken = ~i_f.eq;
         JC_UGT:  o_taken = ~i_f.ult & ~i_f.eq;
         JC_UGE:  o_taken = ~i_f.ult;
         JC_ULT:  o_taken = i_f.ult;
         JC_ULE:  o_taken = i_f.ult | i_f.eq;
         JC_SGT:  o_taken = ~i_f.slt & ~i_f.eq;
         JC_SGE:  o_taken = ~i_f.slt;
         JC_SLT:  o_taken = i_f.slt;
         JC_SLE:  o_taken = i_f.slt | i_f.eq;
         JC_TEST: o_taken = i_f.any;
         default: o_illegal = 1'b1;
      endcase
   end
endmodule

// File: rtl/bcu_target.sv
module bcu_target #(
   parameter int PC_W  = 32,
   parameter int OFF_W = 16,
   parameter int IMM_W = 32
) (
   input  logic [PC_W-1:0]  i_pc,
   input  logic             i_cls32,
   input  logic             i_always,
   input  logic [OFF_W-1:0] i_off,
   input  logic [IMM_W-1:0] i_imm,
   input  logic             i_taken,
   output logic [PC_W-1:0]  o_next_pc
);
   logic [PC_W-1:0] off_ext;
   logic [PC_W-1:0] imm_ext;
   logic [PC_W-1:0] disp;
   logic [PC_W-1:0] pc_inc;

   assign off_ext   = PC_W'($signed(i_off));
   assign imm_ext   = PC_W'($signed(i_imm));
   // only the narrow-class unconditional jump reaches with the immediate
   assign disp      = (i_cls32 && i_always) ? imm_ext : off_ext;
   assign pc_inc    = i_pc + PC_W'(1);
   assign o_next_pc = i_taken ? (pc_inc + disp) : pc_inc;
endmodule

// File: rtl/bcu_branch_unit.sv
module bcu_branch_unit
   import bcu_pkg::*;
#(
   parameter int PC_W    = 32,
   parameter int DATA_W  = 64,
   parameter int OFF_W   = 16,
   parameter int IMM_W   = 32,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              i_vld,
   input  logic [PC_W-1:0]   i_pc,
   input  logic              i_cls32,
   input  logic [3:0]        i_code,
   input  logic              i_use_reg,
   input  logic [DATA_W-1:0] i_dst,
   input  logic [DATA_W-1:0] i_src,
   input  logic [OFF_W-1:0]  i_off,
   input  logic [IMM_W-1:0]  i_imm,
   output logic              o_vld,
   output logic              o_taken,
   output logic [PC_W-1:0]   o_next_pc,
   output logic              o_illegal
);
   localparam int HALF_W  = DATA_W / 2;
   localparam int N_LANES = 2;

   if ((DATA_W % 2) != 0 || IMM_W > DATA_W) begin : g_bad_data_w
      $error("bcu_branch_unit: DATA_W must be even and at least IMM_W");
   end
   if (PC_W < IMM_W || PC_W < OFF_W || PC_W > 64) begin : g_bad_pc_w
      $error("bcu_branch_unit: PC_W must cover both displacements and stay within 64");
   end

   jcode_e            code_e;
   logic [DATA_W-1:0] opnd_b;
   cmp_flags_t        lane_f [N_LANES];
   cmp_flags_t        sel_f;
   logic              c_taken;
   logic              c_illegal;
   logic [PC_W-1:0]   c_next_pc;

   assign code_e = jcode_e'(i_code);

   bcu_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opsel (
      .i_src     (i_src),
      .i_imm     (i_imm),
      .i_use_reg (i_use_reg),
      .o_b       (opnd_b)
   );

   // lane 0 compares the full width, lane 1 the low half
   for (genvar g = 0; g < N_LANES; g++) begin : g_lane
      localparam int LW = (g == 0) ? DATA_W : HALF_W;
      bcu_compare #(.W(LW)) u_cmp (
         .i_a     (i_dst[LW-1:0]),
         .i_b     (opnd_b[LW-1:0]),
         .o_flags (lane_f[g])
      );
   end

   assign sel_f = i_cls32 ? lane_f[1] : lane_f[0];

   bcu_cond_decode u_dec (
      .i_code    (code_e),
      .i_use_reg (i_use_reg),
      .i_f       (sel_f),
      .o_taken   (c_taken),
      .o_illegal (c_illegal)
   );

   bcu_target #(.PC_W(PC_W), .OFF_W(OFF_W), .IMM_W(IMM_W)) u_tgt (
      .i_pc      (i_pc),
      .i_cls32   (i_cls32),
      .i_always  (code_e == JC_ALWAYS),
      .i_off     (i_off),
      .i_imm     (i_imm),
      .i_taken   (c_taken),
      .o_next_pc (c_next_pc)
   );

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            o_vld     <= 1'b0;
            o_taken   <= 1'b0;
            o_illegal <= 1'b0;
            o_next_pc <= '0;
         end else begin
            o_vld <= i_vld;
            if (i_vld) begin
               o_taken   <= c_taken;
               o_illegal <= c_illegal;
               o_next_pc <= c_next_pc;
            end
         end
      end

      assert_vld_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
         o_vld == $past(i_vld));

      assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
         !i_vld |=> ($stable(o_taken) && $stable(o_illegal) && $stable(o_next_pc)));

      assert_fallthrough_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (o_vld && !o_taken) |-> (o_next_pc == $past(i_pc) + PC_W'(1)));

      assert_always_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (i_vld && i_code == 4'h0 && !i_use_reg) |=> o_taken);

      assert_eq_wide_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (i_vld && i_code == 4'h1 && !i_cls32 && i_use_reg && i_dst == i_src) |=> o_taken);

      assert_illegal_not_taken_R10: assert property (@(posedge clk) disable iff (!rst_n)
         o_illegal |-> !o_taken);
   end else begin : g_comb
      assign o_vld     = rst_n & i_vld;
      assign o_taken   = rst_n & c_taken;
      assign o_illegal = rst_n & c_illegal;
      assign o_next_pc = rst_n ? c_next_pc : '0;

      assert_illegal_not_taken_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (i_vld && o_illegal) |-> !o_taken);
   end
endmodule

// File: tb/test_bcu_branch_unit.sv
module test_bcu_branch_unit;
   localparam int PC_W = 32;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        i_vld = 1'b0;
   logic [31:0] i_pc = '0;
   logic        i_cls32 = 1'b0;
   logic [3:0]  i_code = '0;
   logic        i_use_reg = 1'b0;
   logic [63:0] i_dst = '0;
   logic [63:0] i_src = '0;
   logic [15:0] i_off = '0;
   logic [31:0] i_imm = '0;
   logic        o_vld, o_taken, o_illegal;
   logic [31:0] o_next_pc;

   always #4 clk = ~clk;

   bcu_branch_unit i_bcu_branch_unit (
      .clk(clk), .rst_n(rst_n), .i_vld(i_vld), .i_pc(i_pc), .i_cls32(i_cls32),
      .i_code(i_code), .i_use_reg(i_use_reg), .i_dst(i_dst), .i_src(i_src),
      .i_off(i_off), .i_imm(i_imm), .o_vld(o_vld), .o_taken(o_taken),
      .o_next_pc(o_next_pc), .o_illegal(o_illegal)
   );

   int checks = 0;
   int failures = 0;
   logic        exp_vld = 1'b0, exp_taken = 1'b0, exp_ill = 1'b0;
   logic [31:0] exp_npc = '0;
   string       exp_tag = "R11";

   task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // behavioural reference for one jump
   function automatic void model(input bit c32, input logic [3:0] code, input bit ur,
                                 input logic [63:0] d, input logic [63:0] s,
                                 input logic [15:0] off, input logic [31:0] imm,
                                 input logic [31:0] pc, output bit tk, output bit ill,
                                 output logic [31:0] npc, output string tag);
      logic [63:0] b, ua, ub, sa, sb;
      longint signed disp;
      b = ur ? s : {{32{imm[31]}}, imm};
      if (c32) begin
         ua = {32'h0, d[31:0]};       ub = {32'h0, b[31:0]};
         sa = {{32{d[31]}}, d[31:0]}; sb = {{32{b[31]}}, b[31:0]};
      end else begin
         ua = d; ub = b; sa = d; sb = b;
      end
      tk = 0; ill = 0;
      case (code)
         4'h0: begin ill = ur; tk = !ur; end
         4'h1: tk = (ua == ub);
         4'h5: tk = (ua != ub);
         4'h2: tk = (ua > ub);
         4'h3: tk = (ua >= ub);
         4'ha: tk = (ua < ub);
         4'hb: tk = (ua <= ub);
         4'h6: tk = ($signed(sa) > $signed(sb));
         4'h7: tk = ($signed(sa) >= $signed(sb));
         4'hc: tk = ($signed(sa) < $signed(sb));
         4'hd: tk = ($signed(sa) <= $signed(sb));
         4'h4: tk = ((ua & ub) != 0);
         default: ill = 1;
      endcase
      if (c32 && code == 4'h0) disp = longint'($signed(imm));
      else disp = longint'($signed(off));
      npc = tk ? 32'(longint'(pc) + 1 + disp) : pc + 32'd1;
      if (ill) tag = "R10";
      else if (code == 4'h0) tag = "R3";
      else if (c32) tag = "R8";
      else if (!ur) tag = "R9";
      else if (code == 4'h1 || code == 4'h5) tag = "R4";
      else if (code == 4'h4) tag = "R7";
      else if (code == 4'h6 || code == 4'h7 || code >= 4'hc) tag = "R6";
      else tag = "R5";
   endfunction

   task automatic compare_outputs();
      chk("R11", "o_vld", 64'(o_vld), 64'(exp_vld));
      if (exp_vld) begin
         chk(exp_tag, "o_taken", 64'(o_taken), 64'(exp_taken));
         chk(exp_ill ? "R10" : exp_tag, "o_illegal", 64'(o_illegal), 64'(exp_ill));
         chk(exp_taken ? exp_tag : "R2", "o_next_pc", 64'(o_next_pc), 64'(exp_npc));
      end else begin
         chk("R11", "held o_taken", 64'(o_taken), 64'(exp_taken));
         chk("R11", "held o_illegal", 64'(o_illegal), 64'(exp_ill));
         chk("R11", "held o_next_pc", 64'(o_next_pc), 64'(exp_npc));
      end
   endtask

   task automatic step(input bit v, input bit c32, input logic [3:0] code, input bit ur,
                       input logic [63:0] d, input logic [63:0] s, input logic [15:0] off,
                       input logic [31:0] imm, input logic [31:0] pc);
      bit tk, ill;
      logic [31:0] npc;
      string tag;
      @(negedge clk);
      compare_outputs();
      i_vld = v; i_cls32 = c32; i_code = code; i_use_reg = ur;
      i_dst = d; i_src = s; i_off = off; i_imm = imm; i_pc = pc;
      if (v) begin
         model(c32, code, ur, d, s, off, imm, pc, tk, ill, npc, tag);
         exp_taken = tk; exp_ill = ill; exp_npc = npc; exp_tag = tag;
      end
      exp_vld = v;
   endtask

   function automatic logic [63:0] pick();
      case ($urandom_range(0, 7))
         0: return 64'h0;
         1: return 64'h1;
         2: return 64'hFFFF_FFFF_FFFF_FFFF;
         3: return 64'h0000_0000_8000_0000;
         4: return 64'h0000_0000_7FFF_FFFF;
         5: return 64'h8000_0000_0000_0000;
         6: return {32'($urandom_range(0, 3)), 32'($urandom_range(0, 3))};
         default: return {$urandom(), $urandom()};
      endcase
   endfunction

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1", "reset o_vld", 64'(o_vld), 64'h0);
      chk("R1", "reset o_taken", 64'(o_taken), 64'h0);
      chk("R1", "reset o_illegal", 64'(o_illegal), 64'h0);
      chk("R1", "reset o_next_pc", 64'(o_next_pc), 64'h0);
      rst_n = 1'b1;

      // R3 wide-class unconditional, offset -3 from slot 100 -> 98
      step(1, 0, 4'h0, 0, 0, 0, 16'hFFFD, 32'h0, 32'd100);
      // R3 narrow-class unconditional uses the immediate, not the offset
      step(1, 1, 4'h0, 0, 0, 0, 16'd5, 32'h0000_1000, 32'd200);
      step(1, 1, 4'h0, 0, 0, 0, 16'd5, 32'hFFFF_FF00, 32'd200);
      // R10 illegal encodings
      step(1, 0, 4'h0, 1, 0, 0, 16'd7, 32'd9, 32'd10);
      for (int c = 8; c < 16; c++)
         if (c == 8 || c == 9 || c == 14 || c == 15)
            step(1, c[0], 4'(c), 1, 5, 5, 16'd3, 0, 32'd40);
      // R4 equality / inequality
      step(1, 0, 4'h1, 1, 64'h1234, 64'h1234, 16'd4, 0, 32'd50);
      step(1, 0, 4'h5, 1, 64'h1234, 64'h1234, 16'd4, 0, 32'd50);
      // R5 vs R6: all-ones against one
      step(1, 0, 4'h2, 1, '1, 64'h1, 16'd8, 0, 32'd60);
      step(1, 0, 4'h6, 1, '1, 64'h1, 16'd8, 0, 32'd60);
      step(1, 0, 4'hc, 1, '1, 64'h1, 16'd8, 0, 32'd60);
      // R8 upper halves differ, low halves equal
      step(1, 1, 4'h1, 1, 64'h1_0000_0005, 64'h2_0000_0005, 16'd2, 0, 32'd70);
      step(1, 0, 4'h1, 1, 64'h1_0000_0005, 64'h2_0000_0005, 16'd2, 0, 32'd70);
      step(1, 1, 4'hc, 1, 64'h0000_0000_8000_0000, 64'h0, 16'd2, 0, 32'd70);
      step(1, 0, 4'hc, 1, 64'h0000_0000_8000_0000, 64'h0, 16'd2, 0, 32'd70);
      // R9 immediate sign-extension
      step(1, 0, 4'h1, 0, '1, 0, 16'd3, 32'hFFFF_FFFF, 32'd80);
      step(1, 1, 4'h1, 0, 64'h0000_0000_FFFF_FFFF, 0, 16'd3, 32'hFFFF_FFFF, 32'd80);
      step(1, 0, 4'h1, 0, 64'h0000_0000_FFFF_FFFF, 0, 16'd3, 32'hFFFF_FFFF, 32'd80);
      // R7 bit test
      step(1, 0, 4'h4, 1, 64'hF0, 64'h0F, 16'd3, 0, 32'd90);
      step(1, 0, 4'h4, 1, 64'hF0, 64'h10, 16'd3, 0, 32'd90);
      // R2 wrap of the fall-through address
      step(1, 0, 4'h1, 1, 64'd1, 64'd2, 16'd3, 0, 32'hFFFF_FFFF);
      // R11 hold across idle cycles
      step(0, 0, 4'h1, 1, 64'd7, 64'd7, 16'd3, 0, 32'd5);
      step(0, 1, 4'h0, 0, 64'd0, 64'd0, 16'd9, 0, 32'd6);

      for (int n = 0; n < 3000; n++) begin
         logic [63:0] d, s;
         d = pick();
         s = ($urandom_range(0, 3) == 0) ? d : pick();
         step($urandom_range(0, 5) != 0, 1'($urandom()), 4'($urandom()),
              $urandom_range(0, 3) != 0, d, s, 16'($urandom()),
              ($urandom_range(0, 1) != 0) ? s[31:0] : $urandom(), $urandom());
      end
      step(0, 0, 0, 0, 0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0, 0, 0, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule